// File: doc/BRIEF.md
# Dual-Standard Interlaced Video Sync Generator

This block derives the horizontal drive, vertical drive, composite sync and composite blanking pulses for interlaced 525-line and 625-line video from one sampling clock. A half-line divider counts clocks within each half-line. A field counter counts half-lines, so one wrap of the field counter is one field. The number of clocks in a half-line depends on the selected standard and on whether the clock is a component-rate or a composite-rate sampling clock.

Composite rates give a non-integer number of clocks per line. For these rates the half-line divider switches between a short length and that length plus one clock. A fractional accumulator picks the length of each half-line, so the clock count over each frame is exact.

Without a reference the generator runs free. An external vertical reset pulse moves both counters to the start of a field. A reset that arrives while the generator is already within a small window of the field start is ignored, so an input that is already in lock does not cause small phase jumps.

Top module: `vidsync_gen`

## Requirements
- R1: In component format (fmt_comp=1), every half-line lasts HALF_C525 clocks (default 572) with std_525=1 and HALF_C625 clocks (default 576) with std_525=0.
- R2: In composite format (fmt_comp=0), half-line k since reset lasts S clocks, or S+1 clocks exactly when k≥1 and floor(k·NUM/DEN) > floor((k−1)·NUM/DEN). The values are S=568, NUM/DEN=3/4 for 525 lines, and S=567, NUM/DEN=629/1250 for 625 lines.
- R3: A field is 525 half-lines (std_525=1) or 625 half-lines (std_525=0). hl_second toggles at every half-line boundary, field boundaries included, and is 0 on half-line 0 after reset.
- R4: hd is high exactly when hl_second=0 and hl_pos < HD_W.
- R5: vd is high for every clock of field half-lines 0 to VD_HL−1 (default 6), and low on all other half-lines.
- R6: csync is high when hl_pos < EQ_W on field half-lines 0–5 and 12–17. On half-lines 6–11 it is high when hl_pos + SERR_W < half-line length. On all other half-lines it is high when hl_second=0 and hl_pos < HSYNC_W.
- R7: blank is high for every clock of field half-lines below VBLK_525 (40) or VBLK_625 (50). On all other half-lines it is high when hl_second=0 and hl_pos < HBLK_W.
- R8: While rst is high (synchronous, active high), hl_pos=0, hl_second=0, the field half-line index is 0 and the fractional accumulator is cleared. The first half-line after reset has the short length.
- R9: A vreset sampled outside the lock window puts the generator at the field start on the next clock: hl_pos=0, half-line index 0, hl_second=0.
- R10: A vreset sampled inside the lock window has no effect. The window is half-line 0 with hl_pos < WIN, or the last half-line of the field with hl_pos + WIN ≥ half-line length.
- R11: In composite format, half-lines 1 to 1050 (525 lines) total 1050·S+787 clocks, and half-lines 1 to 1250 (625 lines) total 1250·S+629 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| std_525 | input | 1 | 1: 525-line standard, 0: 625-line standard (static, change under reset) |
| fmt_comp | input | 1 | 1: component-rate clock, 0: composite-rate clock (static, change under reset) |
| vreset | input | 1 | Vertical reset request, one clock pulse |
| hd | output | 1 | Horizontal drive pulse |
| vd | output | 1 | Vertical drive pulse |
| csync | output | 1 | Composite sync, active high |
| blank | output | 1 | Composite blanking, active high |
| hl_pos | output | HPW | Clock position within the current half-line |
| hl_second | output | 1 | 1 on the second half of a line |

## Verification
Two conditions are the hardest to reach from the ports. The first is the late edge of the lock window, which only occurs on the last half-line of a field. The second is the exact frame total, which only appears after a whole frame of accumulator steps. With default lengths either one takes hundreds of thousands of clocks. The bench therefore overrides the half-line length parameters with short values and keeps the real field lengths and fractions, so whole fields and frames fit in the run. It then counts clocks from a forced field start to place vreset exactly one clock inside and one clock outside each window edge.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  // Vertical interval: three groups of six half-lines
  localparam int EQ_HLINES = 6;

  typedef enum logic [1:0] {
    REG_PRE_EQ,
    REG_SERR,
    REG_POST_EQ,
    REG_ACTIVE
  } vreg_e;

  function automatic vreg_e region_of(input int vidx);
    if (vidx < EQ_HLINES)          return REG_PRE_EQ;
    else if (vidx < 2 * EQ_HLINES) return REG_SERR;
    else if (vidx < 3 * EQ_HLINES) return REG_POST_EQ;
    else                           return REG_ACTIVE;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vsg_hl_div.sv
// Half-line divider: short length or short+1, chosen by a fractional accumulator
module vsg_hl_div #(
  parameter int HPW  = 10,
  parameter int ACCW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic [HPW-1:0]  mod_short,
  input  logic [ACCW-1:0] frac_num,
  input  logic [ACCW-1:0] frac_den,
  output logic [HPW-1:0]  pos,
  output logic [HPW-1:0]  cur_len,
  output logic            hl_end
);

  logic [HPW-1:0]  pos_q;
  logic            long_q;
  logic [ACCW-1:0] acc_q;
  logic [ACCW-1:0] acc_sum;
  logic            next_long;

  assign cur_len   = mod_short + HPW'(long_q);
  assign hl_end    = (pos_q == cur_len - HPW'(1));
  assign acc_sum   = acc_q + frac_num;
  assign next_long = (acc_sum >= frac_den);
  assign pos       = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      long_q <= 1'b0;
      acc_q  <= '0;
    end else if (restart || hl_end) begin
      pos_q  <= '0;
      long_q <= next_long;
      acc_q  <= next_long ? (acc_sum - frac_den) : acc_sum;
    end else begin
      pos_q  <= pos_q + HPW'(1);
    end
  end

  // R1/R2: position never reaches the current length
  p_pos_below_len_r1: assert property (@(posedge clk) disable iff (rst)
    pos_q < cur_len) else $error("position overran half-line length");

  // R2: accumulator stays below the denominator
  p_acc_below_den_r2: assert property (@(posedge clk) disable iff (rst)
    acc_q < frac_den) else $error("fraction accumulator overflow");

endmodule

// File: rtl/vsg_field_cnt.sv
// Counts half-lines within a field and tracks which half of a line is current
module vsg_field_cnt #(
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          hl_end,
  input  logic [VW-1:0] field_len,
  output logic [VW-1:0] vidx,
  output logic          second,
  output logic          field_last
);

  logic [VW-1:0] vidx_q;
  logic          second_q;

  assign field_last = (vidx_q == field_len - VW'(1));
  assign vidx       = vidx_q;
  assign second     = second_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      vidx_q   <= '0;
      second_q <= 1'b0;
    end else if (hl_end) begin
      vidx_q   <= field_last ? '0 : vidx_q + VW'(1);
      second_q <= ~second_q;
    end
  end

  // R3: half-line index stays inside the field
  p_vidx_range_r3: assert property (@(posedge clk) disable iff (rst)
    vidx_q < field_len) else $error("half-line index out of field");

  // R3: line half flips at each half-line boundary
  p_second_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (hl_end && !restart) |=> (second_q != $past(second_q)))
    else $error("line half did not toggle");

  // R3: the field wraps after its last half-line
  p_field_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (hl_end && !restart && field_last) |=> (vidx_q == '0))
    else $error("field did not wrap");

endmodule

// File: rtl/vsg_pulse_gen.sv
// Decodes counter state into the four timing pulses
module vsg_pulse_gen
  import vsg_pkg::*;
#(
  parameter int HPW      = 10,
  parameter int VW       = 10,
  parameter int HD_W     = 64,
  parameter int HSYNC_W  = 84,
  parameter int EQ_W     = 42,
  parameter int SERR_W   = 84,
  parameter int HBLK_W   = 200,
  parameter int VD_HL    = 6,
  parameter int VBLK_525 = 40,
  parameter int VBLK_625 = 50
) (
  input  logic [HPW-1:0] pos,
  input  logic [HPW-1:0] cur_len,
  input  logic [VW-1:0]  vidx,
  input  logic           second,
  input  logic           std_525,
  output logic           hd,
  output logic           vd,
  output logic           csync,
  output logic           blank
);

  int p, l, v, vblk;
  logic line_start;

  always_comb begin
    p          = int'(pos);
    l          = int'(cur_len);
    v          = int'(vidx);
    vblk       = std_525 ? VBLK_525 : VBLK_625;
    line_start = !second;
    hd         = line_start && (p < HD_W);
    vd         = (v < VD_HL);
    unique case (region_of(v))
      REG_PRE_EQ, REG_POST_EQ: csync = (p < EQ_W);
      REG_SERR:                csync = (p + SERR_W < l);
      default:                 csync = line_start && (p < HSYNC_W);
    endcase
    blank = (v < vblk) || (line_start && (p < HBLK_W));
  end

endmodule

// File: rtl/vidsync_gen.sv
module vidsync_gen
  import vsg_pkg::*;
#(
  parameter int HALF_C525 = 572,
  parameter int HALF_C625 = 576,
  parameter int HALF_S525 = 568,
  parameter int HALF_S625 = 567,
  parameter int NUM_525   = 3,
  parameter int DEN_525   = 4,
  parameter int NUM_625   = 629,
  parameter int DEN_625   = 1250,
  parameter int HL_525    = 525,
  parameter int HL_625    = 625,
  parameter int HD_W      = 64,
  parameter int HSYNC_W   = 84,
  parameter int EQ_W      = 42,
  parameter int SERR_W    = 84,
  parameter int HBLK_W    = 200,
  parameter int VD_HL     = 6,
  parameter int VBLK_525  = 40,
  parameter int VBLK_625  = 50,
  parameter int WIN       = 81,
  localparam int MAXM = max2(max2(HALF_C525, HALF_C625), max2(HALF_S525, HALF_S625) + 1),
  localparam int HPW  = $clog2(MAXM + 1),
  localparam int ACCW = $clog2(max2(DEN_525, DEN_625)) + 1,
  localparam int VW   = $clog2(max2(HL_525, HL_625))
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           std_525,
  input  logic           fmt_comp,
  input  logic           vreset,
  output logic           hd,
  output logic           vd,
  output logic           csync,
  output logic           blank,
  output logic [HPW-1:0] hl_pos,
  output logic           hl_second
);

  logic [HPW-1:0]  mod_short, pos, cur_len;
  logic [ACCW-1:0] frac_num, frac_den;
  logic [VW-1:0]   field_len, vidx;
  logic            hl_end, second, field_last, in_win, restart;
  int              p_i, l_i;

  // Mode selection of lengths and fraction
  always_comb begin
    if (fmt_comp) begin
      mod_short = std_525 ? HPW'(HALF_C525) : HPW'(HALF_C625);
      frac_num  = '0;
      frac_den  = ACCW'(1);
    end else begin
      mod_short = std_525 ? HPW'(HALF_S525) : HPW'(HALF_S625);
      frac_num  = std_525 ? ACCW'(NUM_525) : ACCW'(NUM_625);
      frac_den  = std_525 ? ACCW'(DEN_525) : ACCW'(DEN_625);
    end
    field_len = std_525 ? VW'(HL_525) : VW'(HL_625);
  end

  // Lock window around the field start
  always_comb begin
    p_i     = int'(pos);
    l_i     = int'(cur_len);
    in_win  = ((vidx == '0) && (p_i < WIN)) || (field_last && (p_i + WIN >= l_i));
    restart = vreset && !in_win;
  end

  vsg_hl_div #(.HPW(HPW), .ACCW(ACCW)) u_hl_div (
    .clk(clk), .rst(rst), .restart(restart),
    .mod_short(mod_short), .frac_num(frac_num), .frac_den(frac_den),
    .pos(pos), .cur_len(cur_len), .hl_end(hl_end)
  );

  vsg_field_cnt #(.VW(VW)) u_field_cnt (
    .clk(clk), .rst(rst), .restart(restart), .hl_end(hl_end),
    .field_len(field_len), .vidx(vidx), .second(second), .field_last(field_last)
  );

  vsg_pulse_gen #(
    .HPW(HPW), .VW(VW), .HD_W(HD_W), .HSYNC_W(HSYNC_W), .EQ_W(EQ_W),
    .SERR_W(SERR_W), .HBLK_W(HBLK_W), .VD_HL(VD_HL),
    .VBLK_525(VBLK_525), .VBLK_625(VBLK_625)
  ) u_pulse_gen (
    .pos(pos), .cur_len(cur_len), .vidx(vidx), .second(second),
    .std_525(std_525), .hd(hd), .vd(vd), .csync(csync), .blank(blank)
  );

  assign hl_pos    = pos;
  assign hl_second = second;

  // R9: an accepted vertical reset lands on the field start
  p_restart_lands_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pos == '0 && vidx == '0 && !second))
    else $error("vertical reset did not reach field start");

  // R10: a reset inside the window leaves the count running
  p_window_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (vreset && in_win && !hl_end) |=> (int'(pos) == $past(int'(pos)) + 1))
    else $error("in-window vertical reset disturbed the count");

  // R5/R7: vertical drive lies within vertical blanking
  p_vd_in_blank_r7: assert property (@(posedge clk) disable iff (rst)
    vd |-> blank) else $error("vd outside blanking");

endmodule

// File: tb/test_vidsync_gen.sv
module test_vidsync_gen;

  localparam int C525 = 24, C625 = 26, S525 = 20, S625 = 21;
  localparam int N525 = 3, D525 = 4, N625 = 629, D625 = 1250;
  localparam int HDW = 4, HSW = 3, EQW = 2, SRW = 3, HBW = 6, WINW = 3;
  localparam int TB_HPW = 5;

  logic clk = 1'b0, rst = 1'b1, std_525 = 1'b1, fmt_comp = 1'b1, vreset = 1'b0;
  logic hd, vd, csync, blank, hl_second;
  logic [TB_HPW-1:0] hl_pos;

  always #4 clk = ~clk;

  vidsync_gen #(
    .HALF_C525(C525), .HALF_C625(C625), .HALF_S525(S525), .HALF_S625(S625),
    .NUM_525(N525), .DEN_525(D525), .NUM_625(N625), .DEN_625(D625),
    .HD_W(HDW), .HSYNC_W(HSW), .EQ_W(EQW), .SERR_W(SRW), .HBLK_W(HBW), .WIN(WINW)
  ) i_vidsync_gen (
    .clk(clk), .rst(rst), .std_525(std_525), .fmt_comp(fmt_comp), .vreset(vreset),
    .hd(hd), .vd(vd), .csync(csync), .blank(blank),
    .hl_pos(hl_pos), .hl_second(hl_second)
  );

  typedef struct { int len; int hdc; int vdc; int csc; int blc; int sec; } item_t;
  item_t q[$];

  int nvec = 0, nfail = 0;
  bit sb_on = 1'b0, done = 1'b0;
  string len_req = "R1";
  int frame_n = 0, tsum = 0, item_idx = 0;
  int c_len = 0, c_hd = 0, c_vd = 0, c_cs = 0, c_bl = 0, c_sec = 0;

  task automatic chk(input int act, input int exp, input string req, input string what);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Expected half-line k since reset, from the requirements
  function automatic item_t exp_item(input int k, input bit s5, input bit cp);
    item_t e;
    int sh, nu, de, nf, v, vb;
    longint a, b;
    sh = cp ? (s5 ? C525 : C625) : (s5 ? S525 : S625);
    nu = cp ? 0 : (s5 ? N525 : N625);
    de = cp ? 1 : (s5 ? D525 : D625);
    a = (longint'(k) * nu) / de;
    b = (k > 0) ? (longint'(k - 1) * nu) / de : a;
    e.len = sh + ((k > 0 && a > b) ? 1 : 0);
    nf = s5 ? 525 : 625;
    vb = s5 ? 40 : 50;
    v = k % nf;
    e.sec = k % 2;
    e.hdc = (e.sec == 0) ? imin(HDW, e.len) : 0;
    e.vdc = (v < 6) ? e.len : 0;
    if (v < 6 || (v >= 12 && v < 18)) e.csc = imin(EQW, e.len);
    else if (v < 12)                  e.csc = e.len - SRW;
    else                              e.csc = (e.sec == 0) ? HSW : 0;
    e.blc = (v < vb) ? e.len : ((e.sec == 0) ? HBW : 0);
    return e;
  endfunction

  // Monitor: measure each half-line and compare with the scoreboard
  always @(negedge clk) begin
    if (rst || !sb_on) begin
      c_len = 0; c_hd = 0; c_vd = 0; c_cs = 0; c_bl = 0;
      item_idx = 0; tsum = 0;
    end else begin
      if (hl_pos == '0 && c_len != 0) begin
        if (q.size() == 0) begin
          nvec++; nfail++;
          $display("FAIL R3 unexpected half-line: actual %0d expected none", c_len);
        end else begin
          item_t e;
          e = q.pop_front();
          chk(c_len, e.len, len_req, "half-line length");
          chk(c_sec, e.sec, "R3", "line half");
          chk(c_hd, e.hdc, "R4", "hd clocks");
          chk(c_vd, e.vdc, "R5", "vd clocks");
          chk(c_cs, e.csc, "R6", "csync clocks");
          chk(c_bl, e.blc, "R7", "blank clocks");
        end
        if (item_idx >= 1 && item_idx <= frame_n) tsum += c_len;
        item_idx++;
        c_len = 0; c_hd = 0; c_vd = 0; c_cs = 0; c_bl = 0;
      end
      if (c_len == 0) c_sec = int'(hl_second);
      c_len++;
      c_hd += int'(hd); c_vd += int'(vd); c_cs += int'(csync); c_bl += int'(blank);
    end
  end

  task automatic drv_step();
    @(posedge clk); #2;
  endtask

  // Driver: reset into a mode, push the expected half-lines, wait for drain
  task automatic run_mode(input bit s5, input bit cp, input int n, input int fn, input string req);
    drv_step();
    rst = 1'b1; sb_on = 1'b0; std_525 = s5; fmt_comp = cp;
    repeat (3) drv_step();
    q.delete();
    for (int k = 0; k < n; k++) q.push_back(exp_item(k, s5, cp));
    len_req = req; frame_n = fn;
    sb_on = 1'b1; rst = 1'b0;
    while (q.size() != 0) @(negedge clk);
    if (fn > 0) begin
      int sh, nu, de;
      sh = s5 ? S525 : S625; nu = s5 ? N525 : N625; de = s5 ? D525 : D625;
      chk(tsum, fn * sh + (fn * nu) / de, "R11", "frame clock total");
    end
    drv_step();
    sb_on = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    // R8: state held in reset
    repeat (3) drv_step();
    @(negedge clk);
    chk(int'(hl_pos), 0, "R8", "hl_pos in reset");
    chk(int'(hl_second), 0, "R8", "hl_second in reset");
    chk(int'(vd), 1, "R8", "vd at field start");
    chk(int'(hd), 1, "R8", "hd at line start");
    chk(int'(csync), 1, "R8", "csync at field start");
    chk(int'(blank), 1, "R8", "blank at field start");

    run_mode(1'b1, 1'b1, 1100, 0, "R1");
    run_mode(1'b0, 1'b1, 1300, 0, "R1");
    run_mode(1'b1, 1'b0, 1100, 1050, "R2");
    run_mode(1'b0, 1'b0, 1260, 1250, "R2");

    // Vertical reset behaviour, 525-line component (24 clocks per half-line)
    drv_step(); rst = 1'b1; std_525 = 1'b1; fmt_comp = 1'b1;
    repeat (3) drv_step();
    rst = 1'b0;
    repeat (3005) drv_step();           // half-line 125, position 5
    chk(int'(vd), 0, "R9", "vd mid-field before reset");
    vreset = 1'b1; drv_step(); vreset = 1'b0;
    @(negedge clk);
    chk(int'(hl_pos), 0, "R9", "hl_pos after forced start");
    chk(int'(vd), 1, "R9", "vd after forced start");
    chk(int'(hl_second), 0, "R9", "hl_second after forced start");

    drv_step();                         // position 1: inside early window
    vreset = 1'b1; drv_step(); vreset = 1'b0;
    @(negedge clk);
    chk(int'(hl_pos), 2, "R10", "early-window reset ignored");

    repeat (525 * 24 - 4) drv_step();   // last half-line, position 22
    chk(int'(hl_pos), 22, "R10", "position before late window");
    vreset = 1'b1; drv_step(); vreset = 1'b0;
    @(negedge clk);
    chk(int'(hl_pos), 23, "R10", "late-window reset ignored");
    chk(int'(vd), 0, "R10", "vd on last half-line");
    drv_step();
    @(negedge clk);
    chk(int'(hl_pos), 0, "R3", "wrap into next field");
    chk(int'(hl_second), 1, "R3", "odd field length flips line half");
    chk(int'(vd), 1, "R5", "vd at start of next field");

    repeat (3) drv_step();              // position 3: first clock outside window
    vreset = 1'b1; drv_step(); vreset = 1'b0;
    @(negedge clk);
    chk(int'(hl_pos), 0, "R9", "reset just outside window accepted");
    chk(int'(hl_second), 0, "R9", "line half cleared by reset");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule